// File: doc/BRIEF.md
# Power Mode and Clock Controller

This block sets the operating mode of a small low-power controller. Software programs three control bits in an 8-bit mode register. One bit enables the frequency-up generator that produces the 3.58 MHz clock. One bit chooses what a HALT does. One bit chooses which clock drives the CPU. A single-cycle HALT strobe from the core moves the controller into one of two halted states. Sleep keeps the 32768 Hz oscillator running. Idle stops it as well.

From the register and the halt state, the block drives four outputs: the enable for the slow oscillator, the enable for the fast clock generator, the system clock select, and a halt line to the CPU. It also reports the current mode as a 2-bit code.

A wake-up input brings the controller out of either halted state back to the slow-clock running mode. The bits that would select the fast clock are cleared at the same moment, so software must request the fast mode again after it resumes. The real oscillators, the clock multiplexer and the frequency multiplier sit outside this block. They follow the enables and the select that it drives.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is held, and after its release until the first write, the mode is Green (01), `cfg_rdata` is 0x00, the slow oscillator is enabled, the fast generator is disabled, the clock select is 0 and `cpu_halt` is 0.
- R2: A write to the register is visible on `cfg_rdata` from the next cycle. Bits 7, 6 and 5 return the written values. Bits 4 to 0 always read 0, whatever was written to them.
- R3: While the CPU is not halted, and bit 7 (clock select) and bit 5 (frequency-up enable) are both 1, the mode is Normal (00). In this mode the slow oscillator is on, the fast generator is on and `sysclk_fast` is 1.
- R4: While the CPU is not halted and bit 7 and bit 5 are not both 1, the mode is Green (01). In this mode `sysclk_fast` is 0, the slow oscillator is on, and the fast generator enable equals bit 5. This means a write of bit 7 = 1 with bit 5 = 0 stays on the slow clock.
- R5: A HALT strobe while running with bit 6 = 0 gives Sleep (10) from the next cycle. In Sleep, `cpu_halt` is 1, the slow oscillator stays on, and both the fast generator enable and the clock select are 0.
- R6: A HALT strobe while running with bit 6 = 1 gives Idle (11) from the next cycle. In Idle, `cpu_halt` is 1 and the slow oscillator enable, the fast generator enable and the clock select are all 0.
- R7: A wake-up pulse in Sleep or Idle gives Green (01) with `cpu_halt` = 0 from the next cycle. It clears register bits 7 and 5 and leaves bit 6 unchanged. A wake-up pulse takes priority over a HALT strobe in the same cycle.
- R8: While halted, register writes and further HALT strobes have no effect. A wake-up pulse while running has no effect.
- R9: A HALT strobe in the same cycle as a register write picks Sleep or Idle from the value of bit 6 held before the write. The write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| halt_req | input | 1 | One-cycle HALT strobe from the core |
| wake | input | 1 | Wake-up pulse |
| mode | output | 2 | 00 Normal, 01 Green, 10 Sleep, 11 Idle |
| slow_osc_en | output | 1 | Enable for the 32768 Hz oscillator |
| fast_gen_en | output | 1 | Enable for the 3.58 MHz generator |
| sysclk_fast | output | 1 | System clock select, 1 = 3.58 MHz |
| cpu_halt | output | 1 | Holds the CPU halted |

## Verification
The assertions check the following on every cycle:
- The halt state is entered after a HALT strobe and left after a wake-up.
- The fast clock is never selected without its generator.
- Nothing fast runs while halted, and Idle always stops the slow oscillator.
- The register holds still through a halt.
- Every exit from a halt lands in Green.

Only the bench's scenarios can show the rest:
- The exact mode code and output set for each of the eight control-bit combinations.
- The masking of the low read bits.
- Which halted state each value of bit 6 picks.
- The same-cycle write and HALT ordering.
- Wake-up priority.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  localparam int unsigned CFG_W    = 8;
  localparam int unsigned UP_BIT   = 5;
  localparam int unsigned IDLE_BIT = 6;
  localparam int unsigned SEL_BIT  = 7;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_GREEN  = 2'b01,
    MODE_SLEEP  = 2'b10,
    MODE_IDLE   = 2'b11
  } pwr_mode_e;

  typedef struct packed {
    logic fast_sel;
    logic halt_idle;
    logic freq_up;
  } ctrl_bits_t;

endpackage

// File: rtl/pmc_rst_sync.sv
module pmc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
  import pwr_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  input  logic             halted_i,
  input  logic             wake_i,
  output ctrl_bits_t       ctrl_o,
  output logic [CFG_W-1:0] rd_data_o
);

  ctrl_bits_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (halted_i) begin
      if (wake_i) begin
        ctrl_d.fast_sel = 1'b0;
        ctrl_d.freq_up  = 1'b0;
      end
    end else if (wr_en_i) begin
      ctrl_d.fast_sel  = wr_data_i[SEL_BIT];
      ctrl_d.halt_idle = wr_data_i[IDLE_BIT];
      ctrl_d.freq_up   = wr_data_i[UP_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  always_comb begin
    rd_data_o           = '0;
    rd_data_o[SEL_BIT]  = ctrl_q.fast_sel;
    rd_data_o[IDLE_BIT] = ctrl_q.halt_idle;
    rd_data_o[UP_BIT]   = ctrl_q.freq_up;
  end

  assign ctrl_o = ctrl_q;

  AST_CTRL_FROZEN_IN_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    halted_i && !wake_i |=> $stable(ctrl_q)); // R8

  AST_WAKE_DROPS_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    halted_i && wake_i |=> !ctrl_q.fast_sel && !ctrl_q.freq_up); // R7

endmodule

// File: rtl/pmc_halt_fsm.sv
module pmc_halt_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_req_i,
  input  logic wake_i,
  input  logic idle_sel_i,
  output logic halted_o,
  output logic idle_o
);

  logic halt_q, halt_d;
  logic idle_q, idle_d;

  always_comb begin
    halt_d = halt_q;
    idle_d = idle_q;
    if (halt_q) begin
      if (wake_i) begin
        halt_d = 1'b0;
        idle_d = 1'b0;
      end
    end else if (halt_req_i) begin
      halt_d = 1'b1;
      idle_d = idle_sel_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
      idle_q <= 1'b0;
    end else begin
      halt_q <= halt_d;
      idle_q <= idle_d;
    end
  end

  assign halted_o = halt_q;
  assign idle_o   = idle_q;

  AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_q && halt_req_i |=> halt_q); // R5

  AST_IDLE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_q && halt_req_i |=> idle_q == $past(idle_sel_i)); // R9

  AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q && wake_i |=> !halt_q); // R7

  AST_RUN_NO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_q |-> !idle_q); // R4

endmodule

// File: rtl/pmc_clk_decode.sv
module pmc_clk_decode
  import pwr_mode_pkg::*;
(
  input  ctrl_bits_t ctrl_i,
  input  logic       halted_i,
  input  logic       idle_i,
  output pwr_mode_e  mode_o,
  output logic       slow_en_o,
  output logic       fast_en_o,
  output logic       sel_fast_o
);

  logic run_fast;

  assign run_fast = ctrl_i.fast_sel & ctrl_i.freq_up;

  always_comb begin
    if (halted_i) begin
      mode_o     = idle_i ? MODE_IDLE : MODE_SLEEP;
      slow_en_o  = ~idle_i;
      fast_en_o  = 1'b0;
      sel_fast_o = 1'b0;
    end else begin
      mode_o     = run_fast ? MODE_NORMAL : MODE_GREEN;
      slow_en_o  = 1'b1;
      fast_en_o  = ctrl_i.freq_up;
      sel_fast_o = run_fast;
    end
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             halt_req,
  input  logic             wake,
  output logic [1:0]       mode,
  output logic             slow_osc_en,
  output logic             fast_gen_en,
  output logic             sysclk_fast,
  output logic             cpu_halt
);

  logic       rst_n_int;
  logic       halted;
  logic       idle;
  ctrl_bits_t ctrl;
  pwr_mode_e  mode_enc;

  pmc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  pmc_ctrl_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_en_i   (cfg_we),
    .wr_data_i (cfg_wdata),
    .halted_i  (halted),
    .wake_i    (wake),
    .ctrl_o    (ctrl),
    .rd_data_o (cfg_rdata)
  );

  pmc_halt_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .halt_req_i (halt_req),
    .wake_i     (wake),
    .idle_sel_i (ctrl.halt_idle),
    .halted_o   (halted),
    .idle_o     (idle)
  );

  pmc_clk_decode u_dec (
    .ctrl_i     (ctrl),
    .halted_i   (halted),
    .idle_i     (idle),
    .mode_o     (mode_enc),
    .slow_en_o  (slow_osc_en),
    .fast_en_o  (fast_gen_en),
    .sel_fast_o (sysclk_fast)
  );

  assign mode     = mode_enc;
  assign cpu_halt = halted;

  AST_SEL_NEEDS_GEN: assert property (@(posedge clk) disable iff (!rst_n_int)
    sysclk_fast |-> fast_gen_en); // R3

  AST_HALT_NO_FAST: assert property (@(posedge clk) disable iff (!rst_n_int)
    cpu_halt |-> !fast_gen_en && !sysclk_fast); // R5

  AST_IDLE_OSC_OFF: assert property (@(posedge clk) disable iff (!rst_n_int)
    mode == MODE_IDLE |-> !slow_osc_en && cpu_halt); // R6

  AST_EXIT_TO_GREEN: assert property (@(posedge clk) disable iff (!rst_n_int)
    $fell(cpu_halt) |-> mode == MODE_GREEN); // R7

endmodule

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;

  localparam time HALF = 4ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic       halt_req;
  logic       wake;
  logic [1:0] mode;
  logic       slow_osc_en, fast_gen_en, sysclk_fast, cpu_halt;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #HALF clk = ~clk;

  pwr_mode_ctrl dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .halt_req    (halt_req),
    .wake        (wake),
    .mode        (mode),
    .slow_osc_en (slow_osc_en),
    .fast_gen_en (fast_gen_en),
    .sysclk_fast (sysclk_fast),
    .cpu_halt    (cpu_halt)
  );

  // {mode[1:0], slow, fast, sel, halt}
  function automatic logic [5:0] outs();
    return {mode, slow_osc_en, fast_gen_en, sysclk_fast, cpu_halt};
  endfunction

  function automatic logic [5:0] exp_run(input bit s, input bit u);
    logic [1:0] m = (s && u) ? 2'b00 : 2'b01;
    return {m, 1'b1, u, s & u, 1'b0};
  endfunction

  function automatic logic [5:0] exp_halt(input bit i);
    logic [1:0] m = i ? 2'b11 : 2'b10;
    return {m, ~i, 1'b0, 1'b0, 1'b1};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // drive for one clock: inputs set at a falling edge, results sampled at the next falling edge
  task automatic step(input bit we, input logic [7:0] d, input bit h, input bit w);
    @(negedge clk);
    cfg_we = we; cfg_wdata = d; halt_req = h; wake = w;
    @(negedge clk);
    cfg_we = 1'b0; halt_req = 1'b0; wake = 1'b0;
  endtask

  initial begin
    #(HALF * 2 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; halt_req = 1'b0; wake = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 held reset outputs", {26'd0, outs()}, {26'd0, 6'b01_1000});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset outputs", {26'd0, outs()}, {26'd0, 6'b01_1000});
    check("R1 reset rdata", {24'd0, cfg_rdata}, 32'h0);

    for (int c = 0; c < 8; c++) begin
      bit s = c[2], i = c[1], u = c[0];
      logic [7:0] wd = {s, i, u, 5'b10110 ^ c[4:0]};
      step(1'b1, wd, 1'b0, 1'b0);
      check("R2 readback", {24'd0, cfg_rdata}, {24'd0, s, i, u, 5'b0});
      if (s && u) check("R3 normal outputs", {26'd0, outs()}, {26'd0, exp_run(s, u)});
      else        check("R4 green outputs", {26'd0, outs()}, {26'd0, exp_run(s, u)});
      step(1'b0, 8'h00, 1'b0, 1'b1);
      check("R8 wake while running", {26'd0, outs()}, {26'd0, exp_run(s, u)});
      step(1'b0, 8'h00, 1'b1, 1'b0);
      if (i) check("R6 idle outputs", {26'd0, outs()}, {26'd0, exp_halt(i)});
      else   check("R5 sleep outputs", {26'd0, outs()}, {26'd0, exp_halt(i)});
      step(1'b1, ~wd, 1'b1, 1'b0);
      check("R8 write/halt ignored outputs", {26'd0, outs()}, {26'd0, exp_halt(i)});
      check("R8 write ignored rdata", {24'd0, cfg_rdata}, {24'd0, s, i, u, 5'b0});
      step(1'b0, 8'h00, 1'b1, 1'b1);
      check("R7 wake outputs", {26'd0, outs()}, {26'd0, exp_run(1'b0, 1'b0)});
      check("R7 wake rdata", {24'd0, cfg_rdata}, {24'd0, 1'b0, i, 1'b0, 5'b0});
    end

    // same-cycle write and halt: bit 6 before the write decides
    step(1'b1, 8'hA0, 1'b0, 1'b0);
    step(1'b1, 8'h40, 1'b1, 1'b0);
    check("R9 old bit6 picks sleep", {26'd0, outs()}, {26'd0, exp_halt(1'b0)});
    check("R9 write applied", {24'd0, cfg_rdata}, 32'h40);
    step(1'b0, 8'h00, 1'b0, 1'b1);
    step(1'b1, 8'hE0, 1'b1, 1'b0);
    check("R9 old bit6 picks idle", {26'd0, outs()}, {26'd0, exp_halt(1'b1)});
    check("R9 second write applied", {24'd0, cfg_rdata}, 32'hE0);
    step(1'b0, 8'h00, 1'b0, 1'b1);
    check("R7 idle exit rdata", {24'd0, cfg_rdata}, 32'h40);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule